// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel of a 16-bit timer. The counter, its zero strobe and a flag saying the timer is running come in from outside. The channel turns counter matches, counter zero or edges on a selected asynchronous input into action requests for four event lines. The requests are clear, set, toggle and pulse. A separate arbiter combines these requests across channels.

In compare mode, a compare register is matched against the counter. That compare register can be reloaded glitch-free from a pipeline register when the counter passes zero. In capture mode, the counter is sampled on a chosen edge of one of up to 64 sources. The sources are synchronised through two flops. A measurement mode also yields the signal period and the width of one phase. Single-shot actions disarm their event enables after they fire.

Whenever the timer is re-enabled, the edge detector is flushed for two clocks. While the timer is stopped the detector holds stale samples, and the flush keeps those samples from producing a false capture.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset, the compare, pipeline, action and capture configuration registers read 0, and no request line is active.
- R2: A compare-triggered action requests its kind in the same cycle that `run` is 1 and `cnt` equals the compare register. With `run` at 0 no request is ever raised.
- R3: The action field holds the event enables in bits [7:4] and the code in bits [3:0]. The codes are:
  - 0: none
  - 1: set on compare, single-shot
  - 2: clear on compare, single-shot
  - 3: toggle on compare, single-shot
  - 4: pulse on compare, single-shot
  - 5: set on capture, single-shot
  - 6: clear on capture, single-shot
  - 7: pulse on capture, single-shot
  - 8: set on compare
  - 9: clear on compare
  - 10: toggle on compare
  - 11: pulse on compare
  - 12: set on capture
  - 13: pulse on capture
  - 14: period/width measurement, which pulses on capture
  - 15: clear on counter zero
- R4: A request appears only on event lines whose enable bit is 1. Enable bit 4+i drives line i.
- R5: A pipeline write is copied into the compare register at the next `cnt_zero` seen while `run` is 1. It is not copied while `run` is 0, not when no write is pending, and not while a capture code (5, 6, 7, 12, 13, 14) is selected.
- R6: In a capture code, `cnt` is stored in the compare register two clocks after the selected edge of the input reaches the synchroniser, and the code's request is raised one clock earlier. The capture field is bits [6:1] for the source and bit 0 for the edge (1 rising, 0 falling). The other edge causes no capture.
- R7: A source number of `NSRC` or more never captures, yet reads back exactly as written.
- R8: When a single-shot code (1 to 7) fires, its four enables are cleared on the next clock. Continuous codes keep their enables.
- R9: While `run` is 0 the edge detector is frozen. For two clocks after `run` rises, the detector is flushed, so an input change that happened while stopped causes no capture.
- R10: In code 14, the compare register receives the count difference between successive selected edges. The pipeline register receives the difference from a selected edge to the following opposite edge, which is the high phase for rising and the low phase for falling.
- R11: A `chan_rst` pulse clears the compare, pipeline, action and capture configuration registers.
- R12: Code 15 requests a clear on its enabled lines in the cycle `cnt_zero` is 1 while `run` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt | input | CNT_W | Current counter value |
| cnt_zero | input | 1 | Counter-at-zero strobe |
| run | input | 1 | Timer mode is not disabled |
| src_bus | input | NSRC | Asynchronous capture sources |
| chan_rst | input | 1 | Channel reset pulse |
| wr_data | input | CNT_W | Write data for all channel registers |
| wr_act | input | 1 | Write action field (enables and code) |
| wr_cap | input | 1 | Write capture field (source and edge) |
| wr_cmp | input | 1 | Write compare register |
| wr_pipe | input | 1 | Write pipeline register |
| cmp_q | output | CNT_W | Compare/capture register |
| pipe_q | output | CNT_W | Pipeline register |
| act_q | output | NUM_EV+4 | Action field readback |
| cap_q | output | SEL_W+1 | Capture field readback |
| req_clr | output | NUM_EV | Clear requests per event line |
| req_set | output | NUM_EV | Set requests per event line |
| req_tgl | output | NUM_EV | Toggle requests per event line |
| req_pls | output | NUM_EV | Pulse requests per event line |

## Verification
The bench builds the channel with its defaults: 16-bit count, four event lines, a 6-bit source select and `NSRC` = 40. With these values all 16 codes can be crossed with all 16 enable patterns. The full 64-value source select is swept, which covers both the 40 wired sources and the 24 unwired values that must stay silent. The 16-bit count allows period and width differences to be checked by plain subtraction.

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel #(
  parameter int CNT_W  = 16,
  parameter int NUM_EV = 4,
  parameter int SEL_W  = 6,
  parameter int NSRC   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_zero,
  input  logic              run,
  input  logic [NSRC-1:0]   src_bus,
  input  logic              chan_rst,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              wr_act,
  input  logic              wr_cap,
  input  logic              wr_cmp,
  input  logic              wr_pipe,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [CNT_W-1:0]  pipe_q,
  output logic [NUM_EV+3:0] act_q,
  output logic [SEL_W:0]    cap_q,
  output logic [NUM_EV-1:0] req_clr,
  output logic [NUM_EV-1:0] req_set,
  output logic [NUM_EV-1:0] req_tgl,
  output logic [NUM_EV-1:0] req_pls
);
  localparam int ACT_W = NUM_EV + 4;
  localparam int NSEL  = 1 << SEL_W;

  logic [3:0]        code;
  logic [NUM_EV-1:0] en;
  logic [1:0]        kind, trig;
  assign code = act_q[3:0];
  assign en   = act_q[ACT_W-1:4];

  // kind: 0 clr 1 set 2 tgl 3 pls ; trig: 0 none 1 compare 2 capture 3 zero
  always_comb begin
    kind = 2'd0;
    trig = 2'd0;
    case (code)
      4'd1:  begin kind = 2'd1; trig = 2'd1; end
      4'd2:  begin kind = 2'd0; trig = 2'd1; end
      4'd3:  begin kind = 2'd2; trig = 2'd1; end
      4'd4:  begin kind = 2'd3; trig = 2'd1; end
      4'd5:  begin kind = 2'd1; trig = 2'd2; end
      4'd6:  begin kind = 2'd0; trig = 2'd2; end
      4'd7:  begin kind = 2'd3; trig = 2'd2; end
      4'd8:  begin kind = 2'd1; trig = 2'd1; end
      4'd9:  begin kind = 2'd0; trig = 2'd1; end
      4'd10: begin kind = 2'd2; trig = 2'd1; end
      4'd11: begin kind = 2'd3; trig = 2'd1; end
      4'd12: begin kind = 2'd1; trig = 2'd2; end
      4'd13: begin kind = 2'd3; trig = 2'd2; end
      4'd14: begin kind = 2'd3; trig = 2'd2; end
      4'd15: begin kind = 2'd0; trig = 2'd3; end
      default: begin kind = 2'd0; trig = 2'd0; end
    endcase
  end

  logic single, is_cap, measure;
  assign single  = (code != 4'd0) && !code[3];
  assign is_cap  = (trig == 2'd2);
  assign measure = (code == 4'd14);

  // edge detector with two-flop synchroniser and flush on re-enable
  logic [NSEL-1:0] src_pad;
  logic sel_in, s1, s2, s3, run_d, flush2;
  logic det_on, flushing, rise, fall, cap_hit, opp_hit;
  assign src_pad  = NSEL'(src_bus);
  assign sel_in   = src_pad[cap_q[SEL_W:1]];
  assign det_on   = is_cap && run;
  assign flushing = det_on && (!run_d || flush2);
  assign rise     = s2 && !s3;
  assign fall     = !s2 && s3;
  assign cap_hit  = det_on && !flushing && (cap_q[0] ? rise : fall);
  assign opp_hit  = det_on && !flushing && measure && (cap_q[0] ? fall : rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      run_d <= 1'b0; flush2 <= 1'b0;
    end else begin
      run_d  <= run;
      flush2 <= run && !run_d;
      if (det_on) begin
        s1 <= sel_in;
        s2 <= s1;
        s3 <= flushing ? s1 : s2;
      end
    end
  end

  logic cmp_hit, zero_hit, fire;
  assign cmp_hit  = run && (trig == 2'd1) && (cnt == cmp_q);
  assign zero_hit = run && (trig == 2'd3) && cnt_zero;
  assign fire     = cmp_hit || cap_hit || zero_hit;

  assign req_clr = (fire && kind == 2'd0) ? en : '0;
  assign req_set = (fire && kind == 2'd1) ? en : '0;
  assign req_tgl = (fire && kind == 2'd2) ? en : '0;
  assign req_pls = (fire && kind == 2'd3) ? en : '0;

  logic             pend, reload;
  logic [CNT_W-1:0] mark;
  assign reload = cnt_zero && run && pend && !is_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0; pipe_q <= '0; act_q <= '0; cap_q <= '0;
      pend <= 1'b0; mark <= '0;
    end else if (chan_rst) begin
      cmp_q <= '0; pipe_q <= '0; act_q <= '0; cap_q <= '0;
      pend <= 1'b0; mark <= '0;
    end else begin
      if (wr_act) act_q <= wr_data[ACT_W-1:0];
      else if (fire && single) act_q[ACT_W-1:4] <= '0;
      if (wr_cap) cap_q <= wr_data[SEL_W:0];
      if (wr_cmp) cmp_q <= wr_data;
      else if (cap_hit) cmp_q <= measure ? cnt - mark : cnt;
      else if (reload) cmp_q <= pipe_q;
      if (wr_pipe) pipe_q <= wr_data;
      else if (opp_hit) pipe_q <= cnt - mark;
      if (wr_pipe) pend <= 1'b1;
      else if (reload) pend <= 1'b0;
      if (cap_hit && measure) mark <= cnt;
    end
  end

  AST_REQ_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> ((req_clr | req_set | req_tgl | req_pls) == '0)); // R2
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|req_clr, |req_set, |req_tgl, |req_pls})); // R3
  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_clr | req_set | req_tgl | req_pls) & ~act_q[ACT_W-1:4]) == '0); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_cmp && !chan_rst) |=> (cmp_q == $past(pipe_q))); // R5
  AST_SHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && single && !wr_act && !chan_rst) |=> (act_q[ACT_W-1:4] == '0)); // R8
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cmp && !chan_rst) |=> (cmp_q == $past(cmp_q))); // R9
  AST_CHAN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (cmp_q == '0 && pipe_q == '0 && act_q == '0 && cap_q == '0)); // R11
endmodule

// File: tb/tmr_cc_channel_test.sv
module tmr_cc_channel_test;
  localparam int CNT_W = 16, NUM_EV = 4, SEL_W = 6, NSRC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0, wr_data = '0;
  logic cnt_zero = 1'b0, run = 1'b0, chan_rst = 1'b0;
  logic wr_act = 1'b0, wr_cap = 1'b0, wr_cmp = 1'b0, wr_pipe = 1'b0;
  logic [NSRC-1:0] src_bus = '0;
  logic [CNT_W-1:0] cmp_q, pipe_q;
  logic [NUM_EV+3:0] act_q;
  logic [SEL_W:0] cap_q;
  logic [NUM_EV-1:0] req_clr, req_set, req_tgl, req_pls;

  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  tmr_cc_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_zero(cnt_zero), .run(run),
    .src_bus(src_bus), .chan_rst(chan_rst), .wr_data(wr_data),
    .wr_act(wr_act), .wr_cap(wr_cap), .wr_cmp(wr_cmp), .wr_pipe(wr_pipe),
    .cmp_q(cmp_q), .pipe_q(pipe_q), .act_q(act_q), .cap_q(cap_q),
    .req_clr(req_clr), .req_set(req_set), .req_tgl(req_tgl), .req_pls(req_pls)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input int which, input logic [CNT_W-1:0] d);
    wr_data = d;
    case (which)
      0: wr_act = 1'b1;
      1: wr_cap = 1'b1;
      2: wr_cmp = 1'b1;
      default: wr_pipe = 1'b1;
    endcase
    cyc(1);
    wr_act = 1'b0; wr_cap = 1'b0; wr_cmp = 1'b0; wr_pipe = 1'b0;
  endtask

  task automatic zero_pulse();
    cnt = '0; cnt_zero = 1'b1;
    cyc(1);
    cnt_zero = 1'b0;
  endtask

  // {kind, trig} per R3; kind 0 clr 1 set 2 tgl 3 pls, trig 1 cmp 2 cap 3 zero
  function automatic logic [3:0] spec(input int c);
    case (c)
      1, 8: return {2'd1, 2'd1};
      2, 9: return {2'd0, 2'd1};
      3, 10: return {2'd2, 2'd1};
      4, 11: return {2'd3, 2'd1};
      5, 12: return {2'd1, 2'd2};
      6: return {2'd0, 2'd2};
      7, 13, 14: return {2'd3, 2'd2};
      15: return {2'd0, 2'd3};
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] place(input logic [3:0] e, input logic [1:0] k);
    return {12'd0, e} << (4 * (3 - k));
  endfunction

  logic [15:0] reqs;
  assign reqs = {req_clr, req_set, req_tgl, req_pls};

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] exp_cc;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    chk("R1 cmp", cmp_q, 0); chk("R1 pipe", pipe_q, 0);
    chk("R1 act", act_q, 0); chk("R1 cap", cap_q, 0);
    chk("R1 reqs", reqs, 0);

    // R2 R3 R4 R12 sweep over every code and enable pattern
    wr(2, 16'h1234);
    for (int c = 0; c < 16; c++) begin
      for (int e = 0; e < 16; e++) begin
        logic [3:0] s;
        s = spec(c);
        wr(0, {8'd0, e[3:0], c[3:0]});
        run = 1'b1; cnt = 16'h1234; #1;
        chk("R2/R3/R4 match", reqs, (s[1:0] == 2'd1) ? place(e[3:0], s[3:2]) : 16'd0);
        cnt = 16'h1235; #1;
        chk("R2 mismatch", reqs, 0);
        cnt = 16'h0000; cnt_zero = 1'b1; #1;
        chk("R12 zero", reqs, (s[1:0] == 2'd3) ? place(e[3:0], s[3:2]) : 16'd0);
        run = 1'b0; cnt = 16'h1234; #1;
        chk("R2 stopped", reqs, 0);
        cnt_zero = 1'b0; cnt = '0;
      end
    end

    // R8 single-shot vs continuous
    wr(2, 16'd5);
    wr(0, 16'h00F1);
    run = 1'b1; cnt = 16'd5; #1;
    chk("R8 shot fires", reqs, place(4'hF, 2'd1));
    cyc(1);
    chk("R8 shot disarmed", act_q, 8'h01);
    chk("R8 shot silent", reqs, 0);
    wr(0, 16'h00F8);
    cyc(1);
    chk("R8 continuous kept", act_q, 8'hF8);
    chk("R8 continuous req", reqs, place(4'hF, 2'd1));
    run = 1'b0; cnt = '0;

    // R5 pipeline reload
    wr(2, 16'd10);
    wr(3, 16'd20);
    zero_pulse();
    chk("R5 no reload stopped", cmp_q, 10);
    run = 1'b1;
    zero_pulse();
    chk("R5 reload", cmp_q, 20);
    wr(2, 16'd7);
    zero_pulse();
    chk("R5 no pending", cmp_q, 7);
    wr(0, 16'h000C);
    wr(3, 16'd40);
    zero_pulse();
    chk("R5 capture no reload", cmp_q, 7);

    // R6 capture single source, both edges
    wr(0, 16'h001C);
    wr(1, {9'd0, 6'd3, 1'b1});
    src_bus = '0;
    cyc(4);
    exp_cc = cmp_q;
    cnt = 16'h0AAA;
    src_bus[3] = 1'b1;
    cyc(2);
    chk("R6 req on capture", reqs, place(4'h1, 2'd1));
    cyc(1);
    chk("R6 rising capture", cmp_q, 16'h0AAA);
    cnt = 16'h0BBB; src_bus[3] = 1'b0;
    cyc(4);
    chk("R6 falling ignored", cmp_q, 16'h0AAA);
    wr(1, {9'd0, 6'd3, 1'b0});
    src_bus[3] = 1'b1;
    cyc(4);
    chk("R6 rising ignored", cmp_q, 16'h0AAA);
    src_bus[3] = 1'b0;
    cyc(4);
    chk("R6 falling capture", cmp_q, 16'h0BBB);

    // R6 R7 sweep of all 64 source numbers
    exp_cc = 16'h0BBB;
    for (int s = 0; s < 64; s++) begin
      wr(1, {9'd0, s[5:0], 1'b1});
      cyc(3);
      chk("R7 readback", cap_q, {s[5:0], 1'b1});
      cnt = 16'(s + 100);
      if (s < NSRC) begin
        src_bus = '0;
        src_bus[s] = 1'b1;
        exp_cc = 16'(s + 100);
      end else begin
        src_bus = '1;
      end
      cyc(4);
      chk("R6/R7 source capture", cmp_q, exp_cc);
      src_bus = '0; cnt = 16'(s + 300);
      cyc(4);
      chk("R6 fall no capture", cmp_q, exp_cc);
    end

    // R9 frozen while stopped, flushed on restart
    wr(1, {9'd0, 6'd3, 1'b1});
    cyc(4);
    exp_cc = cmp_q;
    run = 1'b0;
    src_bus[3] = 1'b1; cnt = 16'h0CCC;
    cyc(5);
    chk("R9 frozen", cmp_q, exp_cc);
    run = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R9 flush no req", reqs, 0);
    end
    chk("R9 flush no capture", cmp_q, exp_cc);
    src_bus[3] = 1'b0;
    cyc(4);
    cnt = 16'h0DDD; src_bus[3] = 1'b1;
    cyc(4);
    chk("R9 capture after flush", cmp_q, 16'h0DDD);

    // R10 measurement
    src_bus[3] = 1'b0;
    wr(0, 16'h000E);
    cyc(4);
    cnt = 16'd100; src_bus[3] = 1'b1; cyc(4);
    cnt = 16'd130; src_bus[3] = 1'b0; cyc(4);
    chk("R10 high width", pipe_q, 30);
    cnt = 16'd175; src_bus[3] = 1'b1; cyc(4);
    chk("R10 period rising", cmp_q, 75);
    wr(1, {9'd0, 6'd3, 1'b0});
    cyc(2);
    cnt = 16'd200; src_bus[3] = 1'b0; cyc(4);
    chk("R10 period falling", cmp_q, 25);
    cnt = 16'd260; src_bus[3] = 1'b1; cyc(4);
    chk("R10 low width", pipe_q, 60);
    cnt = 16'd290; src_bus[3] = 1'b0; cyc(4);
    chk("R10 period again", cmp_q, 90);

    // R11 channel reset
    run = 1'b0;
    wr(2, 16'h1111); wr(3, 16'h2222); wr(0, 16'h00A9); wr(1, 16'h0055);
    chan_rst = 1'b1;
    cyc(1);
    chan_rst = 1'b0;
    chk("R11 cmp", cmp_q, 0); chk("R11 pipe", pipe_q, 0);
    chk("R11 act", act_q, 0); chk("R11 cap", cap_q, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule